// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the memory side of a multiple-register load or store. A request carries a base address, a 16-bit register mask, a two-bit stepping mode and a writeback flag. Once the request is accepted, the sequencer walks the set bits of the mask. For each set bit it presents one word transfer, with the word address and the register number. After the last transfer it raises a one-cycle done strobe. On that same cycle it can present the updated base value.

Registers are always served from the lowest number upward, and the lowest-numbered register always gets the lowest address. In the two decrementing modes, the sequencer therefore counts the mask bits first and starts at the bottom of the block. A stack push maps onto decrement-before with writeback. A stack pop maps onto increment-after with writeback. Memory paces the walk with a per-beat ready input.

Top module: `block_xfer_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it, `busy_o`, `xfer_valid_o`, `done_o` and `wb_valid_o` are low.
- R2: An accepted request with N set mask bits produces exactly N transfers. The register numbers are the set bit positions in ascending order.
- R3: Consecutive transfers of one request have addresses that differ by +4.
- R4: Mode encoding: 0 is increment-after, 1 is increment-before, 2 is decrement-after, 3 is decrement-before. In mode 0 the first address is the base. In mode 1 the first address is base+4.
- R5: In mode 2 the first address is base-4N+4. In mode 3 the first address is base-4N.
- R6: A transfer is held, with the same address and register number, for as long as `ready_i` is low. It advances only on a cycle where `ready_i` is high.
- R7: `done_o` is high for the cycle after the last transfer is accepted. An empty mask gives `done_o` in the cycle after the request is accepted, with no transfers at all.
- R8: `wb_valid_o` is high only in the done cycle, and only if the writeback flag of the request was set. `wb_addr_o` is then base+4N in modes 0 and 1, and base-4N in modes 2 and 3. It reads zero otherwise.
- R9: `start_i` is ignored while `busy_o` is high. A request raised in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request strobe |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register selection mask |
| mode_i | input | 2 | Stepping mode (see R4) |
| wb_en_i | input | 1 | Request the updated base |
| ready_i | input | 1 | Memory accepts the current transfer |
| busy_o | output | 1 | Transfers in progress |
| xfer_valid_o | output | 1 | A transfer is presented |
| xfer_addr_o | output | 32 | Word address of the transfer |
| xfer_reg_o | output | 4 | Register number of the transfer |
| done_o | output | 1 | Request complete (one cycle) |
| wb_valid_o | output | 1 | Updated base is valid |
| wb_addr_o | output | 32 | Updated base value |

## Verification
Two things can happen in one cycle here: the done strobe and writeback of one request, and the acceptance of the next request. The bench raises a new request exactly in the done cycle of a previous one. It expects that request's own done and writeback one cycle later, with no transfer in between. Separately, a request poked in the middle of a busy walk must leave the ongoing address and register sequence untouched. Every beat of every request in the sweep is compared against addresses and register numbers computed in the bench.

// File: rtl/bts_pkg.sv
// Shared types for the block transfer sequencer.
// Assumes mode codes are fixed by the request encoding (see brief R4).
package bts_pkg;
    typedef enum logic [1:0] {
        STEP_UP_POST   = 2'd0,
        STEP_UP_PRE    = 2'd1,
        STEP_DOWN_POST = 2'd2,
        STEP_DOWN_PRE  = 2'd3
    } step_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/bts_popcount.sv
// Counts the set bits of a mask.
// Assumes W >= 1; the result is wide enough to hold W.
module bts_popcount #(
    parameter int W   = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] count_o
);
    // purpose: sum every bit of the mask
    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + CW'(bits_i[i]);
        end
    end
endmodule

// File: rtl/bts_lowbit.sv
// Finds the index of the lowest set bit and flags whether it is the only one.
// Assumes the caller ignores idx_o when bits_i is zero.
module bts_lowbit #(
    parameter int W   = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits_i,
    output logic [IW-1:0] idx_o,
    output logic          single_o
);
    // purpose: priority scan from the top so the lowest set bit wins
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits_i[i]) idx_o = IW'(i);
        end
    end

    // purpose: at most one bit set means the current beat is the last
    assign single_o = ((bits_i & (bits_i - W'(1))) == '0);
endmodule

// File: rtl/bts_addr_gen.sv
// Computes the lowest transfer address and the written-back base of a request.
// Assumes ascending register order maps to ascending addresses in every mode.
module bts_addr_gen
    import bts_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4,
    parameter int CW   = 5
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  step_mode_e    mode_i,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] wb_o
);
    logic [AW-1:0] span;

    // purpose: total byte size of the block
    assign span = AW'(count_i) * AW'(STEP);

    // purpose: bottom address of the block and final base per mode
    always_comb begin
        unique case (mode_i)
            STEP_UP_POST: begin
                first_o = base_i;
                wb_o    = base_i + span;
            end
            STEP_UP_PRE: begin
                first_o = base_i + AW'(STEP);
                wb_o    = base_i + span;
            end
            STEP_DOWN_POST: begin
                first_o = base_i - span + AW'(STEP);
                wb_o    = base_i - span;
            end
            default: begin
                first_o = base_i - span;
                wb_o    = base_i - span;
            end
        endcase
    end
endmodule

// File: rtl/block_xfer_seq.sv
// Top of the block transfer sequencer: accepts a request, walks the mask
// lowest bit first, and steps the word address by STEP per accepted beat.
// Assumes memory holds ready_i low to stall; abort handling is external.
module block_xfer_seq
    import bts_pkg::*;
#(
    parameter int AW   = 32,
    parameter int REGS = 16,
    parameter int STEP = 4,
    localparam int IW  = $clog2(REGS),
    localparam int CW  = $clog2(REGS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [REGS-1:0] mask_i,
    input  logic [1:0]    mode_i,
    input  logic          wb_en_i,
    input  logic          ready_i,
    output logic          busy_o,
    output logic          xfer_valid_o,
    output logic [AW-1:0] xfer_addr_o,
    output logic [IW-1:0] xfer_reg_o,
    output logic          done_o,
    output logic          wb_valid_o,
    output logic [AW-1:0] wb_addr_o
);
    seq_state_e      state_q;
    logic [REGS-1:0] rem_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   wb_q;
    logic            wb_en_q;

    logic [CW-1:0]   req_count;
    logic [AW-1:0]   req_first;
    logic [AW-1:0]   req_wb;
    logic [IW-1:0]   cur_idx;
    logic            cur_last;
    logic            accept;
    logic            advance;

    bts_popcount #(.W(REGS)) u_count (
        .bits_i  (mask_i),
        .count_o (req_count)
    );

    bts_addr_gen #(.AW(AW), .STEP(STEP), .CW(CW)) u_addr (
        .base_i  (base_i),
        .count_i (req_count),
        .mode_i  (step_mode_e'(mode_i)),
        .first_o (req_first),
        .wb_o    (req_wb)
    );

    bts_lowbit #(.W(REGS)) u_low (
        .bits_i   (rem_q),
        .idx_o    (cur_idx),
        .single_o (cur_last)
    );

    // purpose: new request taken whenever no walk is in progress
    assign accept  = start_i && (state_q != SQ_RUN);
    // purpose: current beat consumed by memory
    assign advance = (state_q == SQ_RUN) && ready_i;

    // purpose: sequencing state and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            rem_q   <= '0;
            addr_q  <= '0;
            wb_q    <= '0;
            wb_en_q <= 1'b0;
        end else if (accept) begin
            rem_q   <= mask_i;
            addr_q  <= req_first;
            wb_q    <= req_wb;
            wb_en_q <= wb_en_i;
            state_q <= (mask_i == '0) ? SQ_DONE : SQ_RUN;
        end else if (advance) begin
            rem_q  <= rem_q & ~(REGS'(1) << cur_idx);
            addr_q <= addr_q + AW'(STEP);
            if (cur_last) state_q <= SQ_DONE;
        end else if (state_q == SQ_DONE) begin
            state_q <= SQ_IDLE;
        end
    end

    // purpose: drive the outputs from the registered state
    assign busy_o       = (state_q == SQ_RUN);
    assign xfer_valid_o = (state_q == SQ_RUN);
    assign xfer_addr_o  = addr_q;
    assign xfer_reg_o   = cur_idx;
    assign done_o       = (state_q == SQ_DONE);
    assign wb_valid_o   = done_o && wb_en_q;
    assign wb_addr_o    = wb_valid_o ? wb_q : '0;

    // R1: outputs idle right after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!xfer_valid_o && !done_o && !wb_valid_o));

    // R2: register numbers strictly ascend within a walk
    p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && ready_i) |=> (!xfer_valid_o || xfer_reg_o > $past(xfer_reg_o)));

    // R3: address moves by one word per accepted beat
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && ready_i) |=> (!xfer_valid_o || xfer_addr_o == $past(xfer_addr_o) + AW'(STEP)));

    // R6: stalled beat is held
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && !ready_i) |=> (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_reg_o)));

    // R7: done and a transfer never coincide
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && xfer_valid_o));

    // R8: writeback only in the done cycle
    p_wb_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> done_o);

    // R9: a start while busy does not restart the walk
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ready_i) |=> $stable(xfer_addr_o));
endmodule

// File: tb/block_xfer_seq_tb.sv
module block_xfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] mask_i = '0;
    logic [1:0]  mode_i = '0;
    logic        wb_en_i = 1'b0;
    logic        ready_i = 1'b0;
    logic        busy_o, xfer_valid_o, done_o, wb_valid_o;
    logic [31:0] xfer_addr_o, wb_addr_o;
    logic [3:0]  xfer_reg_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    block_xfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .mask_i(mask_i), .mode_i(mode_i), .wb_en_i(wb_en_i), .ready_i(ready_i),
        .busy_o(busy_o), .xfer_valid_o(xfer_valid_o), .xfer_addr_o(xfer_addr_o),
        .xfer_reg_o(xfer_reg_o), .done_o(done_o), .wb_valid_o(wb_valid_o),
        .wb_addr_o(wb_addr_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pop16(input logic [15:0] m);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic int nth_bit(input logic [15:0] m, input int k);
        int seen = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                if (seen == k) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    function automatic logic [15:0] pick_mask(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h8000;
            3: return 16'hFFFF;
            4: return 16'h05D0;
            5: return 16'h00A5;
            6: return 16'h8001;
            default: return 16'h3C3A;
        endcase
    endfunction

    // run one request; poke raises a stray start during the walk (R9)
    task automatic run_op(input logic [31:0] base, input logic [15:0] mask,
                          input logic [1:0] mode, input bit wb, input int rdy, input bit poke);
        int n = pop16(mask);
        logic [31:0] first, wbv;
        int k = 0;
        int t = 0;
        case (mode)
            2'd0: begin first = base;               wbv = base + 32'(4*n); end
            2'd1: begin first = base + 32'd4;       wbv = base + 32'(4*n); end
            2'd2: begin first = base - 32'(4*n) + 32'd4; wbv = base - 32'(4*n); end
            default: begin first = base - 32'(4*n); wbv = base - 32'(4*n); end
        endcase
        @(negedge clk);
        start_i = 1'b1; base_i = base; mask_i = mask; mode_i = mode; wb_en_i = wb;
        @(negedge clk);
        start_i = 1'b0;
        forever begin
            ready_i = (rdy == 0) ? 1'b1 : ((t % 3) != 1);
            if (poke && t == 1) begin
                start_i = 1'b1; mask_i = 16'hFFFF; mode_i = 2'd3; base_i = 32'h0;
            end
            if (done_o) begin
                check(k == n, "R2 R7 beat count", 32'(k), 32'(n));
                check(wb_valid_o == wb, "R8 wb_valid", 32'(wb_valid_o), 32'(wb));
                check(wb_addr_o == (wb ? wbv : 32'h0), "R8 wb_addr", wb_addr_o, wb ? wbv : 32'h0);
                break;
            end
            check(xfer_valid_o == (k < n), "R7 valid", 32'(xfer_valid_o), 32'(k < n));
            if (xfer_valid_o) begin
                check(xfer_addr_o == first + 32'(4*k), "R3 R4 R5 R6 addr", xfer_addr_o, first + 32'(4*k));
                check(32'(xfer_reg_o) == 32'(nth_bit(mask, k)), "R2 reg", 32'(xfer_reg_o), 32'(nth_bit(mask, k)));
                if (ready_i) k++;
            end
            t++;
            if (t > 100) begin
                check(1'b0, "R7 no done", 32'(t), 32'(n));
                break;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        ready_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !xfer_valid_o && !done_o && !wb_valid_o, "R1 reset", 32'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!xfer_valid_o && !done_o, "R1 after reset", 32'(xfer_valid_o), 0);

        // sweep modes, masks, writeback flag and ready patterns
        for (int md = 0; md < 4; md++)
            for (int w = 0; w < 2; w++)
                for (int mi = 0; mi < 8; mi++)
                    run_op(32'h0000_1000 + 32'(mi * 64), pick_mask(mi), 2'(md), w[0], (mi + w) % 2, 1'b0);

        // worked example: mode 0, base 1000, five registers
        run_op(32'd1000, 16'h05D0, 2'd0, 1'b1, 0, 1'b0);
        // R9: start during a busy walk is ignored
        run_op(32'h2000, 16'h00F0, 2'd1, 1'b1, 0, 1'b1);
        run_op(32'h3000, 16'h0F0F, 2'd3, 1'b1, 1, 1'b1);

        // R9: new request raised in the done cycle is accepted
        @(negedge clk);
        start_i = 1'b1; base_i = 32'h40; mask_i = 16'h0003; mode_i = 2'd0; wb_en_i = 1'b0; ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(done_o == 1'b1, "R9 first done", 32'(done_o), 1);
        start_i = 1'b1; base_i = 32'h100; mask_i = 16'h0000; mode_i = 2'd3; wb_en_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && !xfer_valid_o, "R9 back-to-back done", 32'(done_o), 1);
        check(wb_valid_o && wb_addr_o == 32'h100, "R9 R8 back-to-back wb", wb_addr_o, 32'h100);
        @(negedge clk);
        check(!done_o && !wb_valid_o, "R7 single pulse", 32'(done_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule